// File: doc/BRIEF.md
# Wait/Hold Clock Divider with Staged Update

This block derives a domain clock from an already selected source clock by an integer ratio. The ratio comes from two counts held in one configuration word. The wait count sets how many source cycles the output stays high, less one. The hold count sets how many source cycles it stays low, less one. The ratio is therefore wait + hold + 2. A bypass field routes the source clock straight to the output instead. Software computes a ratio R by writing wait = R/2 − 1 and hold = R − wait − 2, and never asks for a ratio below 2.

New counts are staged. They reach the running divider only when software also sets the update field in the same write. That field reads back as 1 until the hardware has loaded the new counts at the end of a complete output period, and then it clears by itself. Software polls it to know that the new rate is in force. A bypass change also waits for a period boundary, so the switch never shortens a phase.

One parameter narrows the count fields for a domain that needs ratios only up to 16. The field positions stay the same in that variant, and the unused upper bits are dropped.

Top module: `wait_hold_div`

## Requirements
- R1: While reset is high and in the first cycle after it, the configuration word reads 0 (wait 0, hold 0, bypass 0, update 0), and the output starts with its high phase at ratio 2.
- R2: With bypass inactive, the output is high for wait+1 source cycles and then low for hold+1 source cycles, repeating, for a ratio of wait+hold+2.
- R3: A write whose bit 25 is 0 changes the staged counts but leaves the running output period unchanged.
- R4: A write with bit 25 set makes bit 25 read 1 from the next cycle. Bit 25 stays 1 until the staged counts load, and it reads 0 from the first high cycle that uses them.
- R5: Staged counts load only after the last low cycle of a complete period, so every high and low phase has its full programmed length, including the phase in which the write arrived.
- R6: Bit 24 set selects bypass, where the output equals the source clock. A bypass change takes effect at the next period boundary without needing bit 25.
- R7: With the count width set to 3, only bits 18:16 (wait) and 22:20 (hold) are kept. Bits 19 and 23 are ignored and read 0, so ratios run from 2 to 16. With width 4, bits 19:16 and 23:20 give ratios 2 to 32.
- R8: A write with bit 25 clear, made while an update is pending, does not cancel the pending update. The later load uses the values of the most recent write.
- R9: Read data places wait at bits 19:16, hold at bits 23:20, bypass at bit 24 and the pending update at bit 25. All other bits read 0.
- R10: When a write with bit 25 set coincides with a load, the load uses the counts staged before that write, and bit 25 stays 1 for the new request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Selected source clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data |
| clk_out | output | 1 | Divided or bypassed domain clock |

## Verification
A wrong phase counter or a wrong active count shows up on `clk_out` within one output period, at most 32 source cycles: a high or low run comes out too short or too long. A fault in the update handshake shows up in bit 25 of the read data. The bit either clears before the period boundary or fails to clear at it, and that is visible in the same cycle the boundary passes. A bypass switch made in the wrong cycle appears as a truncated phase at the boundary. The bench catches this by checking the output level in both halves of every source cycle.

// File: rtl/cdiv_pkg.sv
`timescale 1ns/1ps
package cdiv_pkg;

    localparam int FIELD_W  = 4;
    localparam int WAIT_LSB = 16;
    localparam int HOLD_LSB = 20;
    localparam int BYP_BIT  = 24;
    localparam int UPD_BIT  = 25;
    localparam int WORD_W   = 32;

    typedef enum logic {
        PH_LOW  = 1'b0,
        PH_HIGH = 1'b1
    } phase_e;

    typedef struct packed {
        logic               bypass;
        logic [FIELD_W-1:0] hold_n;
        logic [FIELD_W-1:0] wait_n;
    } div_cfg_t;

    function automatic logic [FIELD_W-1:0] field_mask(input int width);
        logic [FIELD_W-1:0] m;
        m = '0;
        for (int i = 0; i < FIELD_W; i++) begin
            if (i < width) m[i] = 1'b1;
        end
        return m;
    endfunction

    function automatic logic [WORD_W-1:0] pack_word(input div_cfg_t c, input logic pend);
        logic [WORD_W-1:0] w;
        w = '0;
        w[WAIT_LSB +: FIELD_W] = c.wait_n;
        w[HOLD_LSB +: FIELD_W] = c.hold_n;
        w[BYP_BIT]             = c.bypass;
        w[UPD_BIT]             = pend;
        return w;
    endfunction

endpackage

// File: rtl/cdiv_regs.sv
`timescale 1ns/1ps
module cdiv_regs
    import cdiv_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [WORD_W-1:0] wdata,
    input  logic              apply,
    output div_cfg_t          staged,
    output logic              pending,
    output logic [WORD_W-1:0] rdata
);
    localparam logic [FIELD_W-1:0] FMASK = field_mask(CNT_W);

    div_cfg_t staged_q;
    logic     pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            staged_q <= '0;
            pend_q   <= 1'b0;
        end else begin
            if (we) begin
                staged_q.wait_n <= wdata[WAIT_LSB +: FIELD_W] & FMASK;
                staged_q.hold_n <= wdata[HOLD_LSB +: FIELD_W] & FMASK;
                staged_q.bypass <= wdata[BYP_BIT];
            end
            if (we && wdata[UPD_BIT]) begin
                pend_q <= 1'b1;
            end else if (apply) begin
                pend_q <= 1'b0;
            end
        end
    end

    assign staged  = staged_q;
    assign pending = pend_q;
    assign rdata   = pack_word(staged_q, pend_q);

endmodule

// File: rtl/cdiv_phase.sv
`timescale 1ns/1ps
module cdiv_phase
    import cdiv_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  div_cfg_t staged,
    input  logic     pending,
    output logic     apply,
    output logic     boundary,
    output logic     div_hi,
    output div_cfg_t active
);
    phase_e             phase_q;
    logic [FIELD_W-1:0] cnt_q;
    div_cfg_t           act_q;

    assign boundary = (phase_q == PH_LOW) && (cnt_q == act_q.hold_n);
    assign apply    = boundary && pending;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_HIGH;
            cnt_q   <= '0;
            act_q   <= '0;
        end else begin
            unique case (phase_q)
                PH_HIGH: begin
                    if (cnt_q == act_q.wait_n) begin
                        phase_q <= PH_LOW;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                PH_LOW: begin
                    if (boundary) begin
                        phase_q       <= PH_HIGH;
                        cnt_q         <= '0;
                        act_q.bypass  <= staged.bypass;
                        if (pending) begin
                            act_q.wait_n <= staged.wait_n;
                            act_q.hold_n <= staged.hold_n;
                        end
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: begin
                    phase_q <= PH_HIGH;
                    cnt_q   <= '0;
                end
            endcase
        end
    end

    assign div_hi = (phase_q == PH_HIGH);
    assign active = act_q;

endmodule

// File: rtl/cdiv_outmux.sv
`timescale 1ns/1ps
module cdiv_outmux (
    input  logic src_clk,
    input  logic div_hi,
    input  logic sel_bypass,
    output logic clk_out
);
    always_comb begin
        clk_out = sel_bypass ? src_clk : div_hi;
    end
endmodule

// File: rtl/wait_hold_div.sv
`timescale 1ns/1ps
module wait_hold_div
    import cdiv_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_we,
    input  logic [31:0] cfg_wdata,
    output logic [31:0] cfg_rdata,
    output logic        clk_out
);
    div_cfg_t           staged;
    div_cfg_t           active;
    logic               pending;
    logic               apply;
    logic               boundary;
    logic               div_hi;
    logic [FIELD_W-1:0] act_wait;
    logic               act_bypass;

    cdiv_regs #(.CNT_W(CNT_W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .we      (cfg_we),
        .wdata   (cfg_wdata),
        .apply   (apply),
        .staged  (staged),
        .pending (pending),
        .rdata   (cfg_rdata)
    );

    cdiv_phase u_phase (
        .clk      (clk),
        .rst      (rst),
        .staged   (staged),
        .pending  (pending),
        .apply    (apply),
        .boundary (boundary),
        .div_hi   (div_hi),
        .active   (active)
    );

    assign act_wait   = active.wait_n;
    assign act_bypass = active.bypass;

    cdiv_outmux u_mux (
        .src_clk    (clk),
        .div_hi     (div_hi),
        .sel_bypass (act_bypass),
        .clk_out    (clk_out)
    );

endmodule

// File: rtl/wait_hold_div_chk.sv
`timescale 1ns/1ps
module wait_hold_div_chk #(
    parameter int FW = 4
) (
    input logic          clk,
    input logic          rst,
    input logic          cfg_we,
    input logic [31:0]   cfg_wdata,
    input logic [31:0]   cfg_rdata,
    input logic          div_hi,
    input logic          boundary,
    input logic [FW-1:0] act_wait,
    input logic          act_bypass
);
    logic [FW:0] hi_run;

    always_ff @(posedge clk) begin
        if (rst)         hi_run <= '0;
        else if (div_hi) hi_run <= hi_run + 1'b1;
        else             hi_run <= '0;
    end

    assert_reset_word_R1: assert property (@(posedge clk)
        $past(rst) |-> cfg_rdata == 32'h0);

    assert_high_len_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(div_hi) |-> hi_run == ({1'b0, act_wait} + 1'b1));

    assert_update_set_R4: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_wdata[25]) |=> cfg_rdata[25]);

    assert_update_clear_at_edge_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(cfg_rdata[25]) |-> $past(boundary));

    assert_bypass_at_edge_R6: assert property (@(posedge clk) disable iff (rst)
        !$stable(act_bypass) |-> $past(boundary));

    assert_reserved_zero_R9: assert property (@(posedge clk) disable iff (rst)
        cfg_rdata[31:26] == 6'h0 && cfg_rdata[15:0] == 16'h0);

endmodule

bind wait_hold_div wait_hold_div_chk #(.FW(4)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cfg_we     (cfg_we),
    .cfg_wdata  (cfg_wdata),
    .cfg_rdata  (cfg_rdata),
    .div_hi     (div_hi),
    .boundary   (boundary),
    .act_wait   (act_wait),
    .act_bypass (act_bypass)
);

// File: tb/sim_wait_hold_div.sv
`timescale 1ns/1ps
module sim_wait_hold_div;

    typedef struct packed {
        logic        lvl;
        logic        byp;
        logic [31:0] rd;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] rd0, rd1;
    logic        co0, co1;

    int    n_checks = 0;
    int    n_errors = 0;
    bit    done = 0;
    string cur_req = "R1";

    exp_t q0[$];
    exp_t q1[$];
    logic last_byp [2];

    always #5 clk = ~clk;

    wait_hold_div #(.CNT_W(4)) u0 (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(rd0), .clk_out(co0)
    );

    wait_hold_div #(.CNT_W(3)) u1 (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(rd1), .clk_out(co1)
    );

    // Expected behaviour, built from the requirements; state kept per instance
    logic       m_ph   [2];
    logic [3:0] m_cnt  [2];
    logic [3:0] m_aw   [2];
    logic [3:0] m_ah   [2];
    logic       m_ab   [2];
    logic [3:0] m_sw   [2];
    logic [3:0] m_sh   [2];
    logic       m_sb   [2];
    logic       m_p    [2];

    always @(posedge clk) begin
        for (int i = 0; i < 2; i++) begin
            logic [3:0] mask;
            logic       bnd;
            exp_t       e;
            mask = (i == 0) ? 4'hF : 4'h7;
            if (rst) begin
                m_ph[i] = 1'b1; m_cnt[i] = '0;
                m_aw[i] = '0; m_ah[i] = '0; m_ab[i] = 1'b0;
                m_sw[i] = '0; m_sh[i] = '0; m_sb[i] = 1'b0; m_p[i] = 1'b0;
            end else begin
                bnd = !m_ph[i] && (m_cnt[i] == m_ah[i]);
                if (m_ph[i]) begin
                    if (m_cnt[i] == m_aw[i]) begin m_ph[i] = 1'b0; m_cnt[i] = '0; end
                    else m_cnt[i] = m_cnt[i] + 1'b1;
                end else if (bnd) begin
                    m_ph[i] = 1'b1; m_cnt[i] = '0; m_ab[i] = m_sb[i];
                    if (m_p[i]) begin m_aw[i] = m_sw[i]; m_ah[i] = m_sh[i]; end
                end else begin
                    m_cnt[i] = m_cnt[i] + 1'b1;
                end
                if (cfg_we) begin
                    m_sw[i] = cfg_wdata[19:16] & mask;
                    m_sh[i] = cfg_wdata[23:20] & mask;
                    m_sb[i] = cfg_wdata[24];
                end
                if (cfg_we && cfg_wdata[25]) m_p[i] = 1'b1;
                else if (bnd && m_p[i])      m_p[i] = 1'b0;
            end
            e.lvl = m_ab[i] ? 1'b1 : m_ph[i];
            e.byp = m_ab[i];
            e.rd  = {6'h0, m_p[i], m_sb[i], m_sh[i], m_sw[i], 16'h0};
            if (i == 0) q0.push_back(e); else q1.push_back(e);
        end
    end

    task automatic compare(input int inst, input logic act_l, input logic exp_l,
                           input logic [31:0] act_r, input logic [31:0] exp_r);
        n_checks++;
        if (act_l !== exp_l || act_r !== exp_r) begin
            n_errors++;
            $display("FAIL %s u%0d: clk_out=%b rdata=%h expected clk_out=%b rdata=%h",
                     cur_req, inst, act_l, act_r, exp_l, exp_r);
        end
    endtask

    // Monitor: high half of each source cycle
    always @(posedge clk) begin
        exp_t e;
        #1;
        if (q0.size() > 0) begin
            e = q0.pop_front(); last_byp[0] = e.byp;
            compare(0, co0, e.lvl, rd0, e.rd);
        end
        if (q1.size() > 0) begin
            e = q1.pop_front(); last_byp[1] = e.byp;
            compare(1, co1, e.lvl, rd1, e.rd);
        end
    end

    // Monitor: low half of each source cycle, bypass must follow the source (R6)
    always @(negedge clk) begin
        #1;
        if (!rst && last_byp[0] === 1'b1) compare(0, co0, 1'b0, rd0, rd0);
        if (!rst && last_byp[1] === 1'b1) compare(1, co1, 1'b0, rd1, rd1);
    end

    function automatic logic [31:0] word(input logic upd, input logic byp,
                                         input logic [3:0] h, input logic [3:0] w);
        return {6'h0, upd, byp, h, w, 16'h0};
    endfunction

    task automatic write_cfg(input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        cur_req = "R1";
        repeat (3) @(negedge clk);
        n_checks++;
        if (rd0 !== 32'h0) begin
            n_errors++;
            $display("FAIL R1 u0: rdata=%h expected %h", rd0, 32'h0);
        end
        rst = 1'b0;
        cur_req = "R2"; idle(12);
        cur_req = "R3"; write_cfg(word(0, 0, 4'd1, 4'd3)); idle(16);
        cur_req = "R4"; write_cfg(word(1, 0, 4'd1, 4'd3)); idle(30);
        cur_req = "R2"; write_cfg(word(1, 0, 4'd5, 4'd0)); idle(30);
        cur_req = "R8"; write_cfg(word(1, 0, 4'd2, 4'd2));
        write_cfg(word(0, 0, 4'd4, 4'd1)); idle(30);
        cur_req = "R5"; write_cfg(word(1, 0, 4'd7, 4'd7)); idle(3);
        write_cfg(word(1, 0, 4'd2, 4'd1)); idle(50);
        cur_req = "R6"; write_cfg(word(0, 1, 4'd2, 4'd1)); idle(30);
        write_cfg(word(0, 0, 4'd2, 4'd1)); idle(30);
        cur_req = "R7"; write_cfg(word(1, 0, 4'd15, 4'd15)); idle(110);
        write_cfg(word(1, 0, 4'd8, 4'd9)); idle(60);
        cur_req = "R10";
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            cfg_we = 1'b1;
            cfg_wdata = word(1, k[3], 4'(k % 3), 4'(k % 2));
        end
        @(negedge clk); cfg_we = 1'b0;
        cur_req = "R9"; idle(40);
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++; n_errors++;
            $display("FAIL watchdog %s: running=1 expected done=1", cur_req);
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule